// File: doc/BRIEF.md
# ECC Memory Controller Register Bank

This block is the software-visible control and status bank of an ECC memory controller. A processor-side bus reads and writes nine 32-bit word registers: enable, delay, fault status, video configuration, two fault address registers, diagnostic, and two event counters. The hardware error-detection logic reports faults through a separate capture port. That port fills in the fault status and both fault address registers, and it can raise a level interrupt. Software clears the interrupt by writing the fault status register.

A compile-time variant parameter (0, 1 or 2) selects three things:
- the enable-register write mask,
- the 4-bit implementation code that appears in bits 31:28 of the enable register,
- which enable fields survive a warm reset.

Variant 0 also provides a four-byte diagnostic window on its own byte-wide port. There are two resets. The cold reset `cold_rst_ni` clears everything. The warm reset `rst_ni` restores every register except the preserved enable fields.

Top module: `ecc_regbank`

## Requirements
- R1: After cold reset, registers read as follows. Delay (word 1) reads 0x00000020. Fault address 0 (word 4) reads 0x07C00000. Enable (word 0) reads VARIANT<<28. Every other word reads 0, and irq_o is low.
- R2: A full write to enable word 0 stores wdata & MASK into bits 11:0, with MASK = 0x103 for variant 0 and 0xBFF otherwise. Bits 31:28 always read VARIANT and bits 27:12 always read 0.
- R3: A warm reset (rst_ni low, cold_rst_ni high) keeps some enable bits and clears the rest of the enable register. Variant 0 keeps bit 8. Variants 1 and 2 keep bits 11 and 9:2. All other registers return to their R1 values.
- R4: A write to delay word 1 stores wdata & 0x7FFFFFFF.
- R5: A bus write to fault status word 2 stores all 32 bits and drops irq_o on the next clock, unless an error report arrives in the same cycle.
- R6: Fault address words 4 and 5 ignore bus writes. They change only on an error report.
- R7: The main window acts only when req_i is high and be_i == 4'hF. Any other byte-enable pattern writes nothing and reads 0.
- R8: For VARIANT 0, diagnostic byte entry diag_addr_i[1:0] is written with diag_wdata_i and reads back on diag_rdata_o. For other variants diag_rdata_o is always 0.
- R9: An error report (err_valid_i) updates fault status as follows:
  - bit 0 is ORed with err_ce_i,
  - bit 3 is ORed with err_ue_i,
  - bits 7:4 are loaded with err_dw_i,
  - bits 15:8 are loaded with err_syn_i,
  - bit 16 is set if bit 0 or bit 3 was already set.
  
  The same report loads words 4 and 5 from err_addr0_i and err_addr1_i.
- R10: An error report raises irq_o on the next clock if err_ue_i is high, or if err_ce_i is high while enable bit 1 is set. A correctable report with bit 1 clear leaves irq_o unchanged.
- R11: Words 3, 6, 7 and 8 store full 32-bit values, and event counter 1 is independent of event counter 0. Word indexes 9 to 15 read 0 and ignore writes.
- R12: When an error report and a fault-status bus write land in the same cycle, the report wins and the bus write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low async warm reset |
| cold_rst_ni | input | 1 | Active-low async cold reset, clears preserved enable fields too |
| req_i | input | 1 | Main window access strobe |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | ADDR_W | Byte address; word index is addr_i[ADDR_W-1:2] |
| be_i | input | 4 | Byte enables, must be 4'hF |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data |
| diag_req_i | input | 1 | Diagnostic window access strobe |
| diag_we_i | input | 1 | Diagnostic write when high |
| diag_addr_i | input | 2 | Diagnostic byte index |
| diag_wdata_i | input | 8 | Diagnostic write byte |
| diag_rdata_o | output | 8 | Diagnostic read byte |
| err_valid_i | input | 1 | Error report strobe |
| err_ce_i | input | 1 | Correctable error flag |
| err_ue_i | input | 1 | Uncorrectable error flag |
| err_syn_i | input | 8 | Syndrome |
| err_dw_i | input | 4 | Double-word index in block |
| err_addr0_i | input | 32 | Value for fault address 0 |
| err_addr1_i | input | 32 | Value for fault address 1 |
| irq_o | output | 1 | Level interrupt |

## Verification
Three instances, one per variant, share every stimulus. A single walking-one sweep plus an all-ones write through the enable register therefore separates the three masks and implementation codes bit by bit. The walking-one sweep through the delay register isolates the single cleared bit 31.

Warm reset follows an all-ones enable write, so the set of bits that survive differs visibly between variant 0 and the others.

Error reports are sent in a fixed order:
1. correctable with interrupts disabled,
2. uncorrectable onto a set correctable flag,
3. correctable with interrupts enabled,
4. a report colliding with a status write.

Together these separate stickiness, the multiple-error flag, interrupt gating and the priority rule. Partial byte enables, unmapped indexes and fault-address writes are each followed by readbacks that would expose a stray update.

// File: rtl/ecc_regbank_pkg.sv
package ecc_regbank_pkg;

  localparam int unsigned DW = 32;

  localparam int unsigned IDX_ENA  = 0;
  localparam int unsigned IDX_DLY  = 1;
  localparam int unsigned IDX_FSR  = 2;
  localparam int unsigned IDX_VID  = 3;
  localparam int unsigned IDX_FA0  = 4;
  localparam int unsigned IDX_FA1  = 5;
  localparam int unsigned IDX_DGN  = 6;
  localparam int unsigned IDX_EV0  = 7;
  localparam int unsigned IDX_EV1  = 8;

  localparam logic [DW-1:0] DLY_WMASK = 32'h7FFF_FFFF;
  localparam logic [DW-1:0] DLY_RST   = 32'h0000_0020;
  localparam logic [DW-1:0] FA0_RST   = 32'h07C0_0000;

  localparam int unsigned FSR_CE = 0;
  localparam int unsigned FSR_UE = 3;
  localparam int unsigned FSR_ME = 16;

  function automatic logic [11:0] ena_wmask(int unsigned variant);
    return (variant == 0) ? 12'h103 : 12'hBFF;
  endfunction

  // Enable bits that survive a warm reset
  function automatic logic [11:0] ena_keep(int unsigned variant);
    return (variant == 0) ? 12'h100 : 12'hBFC;
  endfunction

endpackage

// File: rtl/ecc_enable_reg.sv
module ecc_enable_reg
  import ecc_regbank_pkg::*;
#(
  parameter int unsigned VARIANT = 0
) (
  input  logic          clk_i,
  input  logic          cold_rst_ni,
  input  logic          rst_any_ni,
  input  logic          wr_i,
  input  logic [11:0]   wdata_i,
  output logic [DW-1:0] ena_o
);

  localparam logic [11:0] WMASK = ena_wmask(VARIANT);
  localparam logic [11:0] KEEP  = ena_keep(VARIANT) & WMASK;
  localparam logic [3:0]  IMPL  = 4'(VARIANT);

  logic [11:0] keep_q, vol_q;

  // Preserved fields: cleared only by cold reset
  always_ff @(posedge clk_i or negedge cold_rst_ni) begin
    if (!cold_rst_ni)  keep_q <= '0;
    else if (wr_i)     keep_q <= wdata_i & KEEP;
  end

  always_ff @(posedge clk_i or negedge rst_any_ni) begin
    if (!rst_any_ni)   vol_q <= '0;
    else if (wr_i)     vol_q <= wdata_i & WMASK & ~KEEP;
  end

  assign ena_o = {IMPL, 16'h0, keep_q | vol_q};

  assert_mask_R2: assert property (@(posedge clk_i) disable iff (!rst_any_ni)
    wr_i |=> ((ena_o[11:0] & ~WMASK) == 12'h0));

endmodule

// File: rtl/ecc_fault_capture.sv
module ecc_fault_capture
  import ecc_regbank_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fsr_wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          ce_irq_en_i,
  input  logic          err_valid_i,
  input  logic          err_ce_i,
  input  logic          err_ue_i,
  input  logic [7:0]    err_syn_i,
  input  logic [3:0]    err_dw_i,
  input  logic [DW-1:0] err_addr0_i,
  input  logic [DW-1:0] err_addr1_i,
  output logic [DW-1:0] fsr_o,
  output logic [DW-1:0] fa0_o,
  output logic [DW-1:0] fa1_o,
  output logic          irq_o
);

  logic [DW-1:0] fsr_q, fa0_q, fa1_q;
  logic          irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsr_q <= '0;
      fa0_q <= FA0_RST;
      fa1_q <= '0;
      irq_q <= 1'b0;
    end else if (err_valid_i) begin
      // Hardware report has priority over a same-cycle bus write
      fsr_q[FSR_CE] <= fsr_q[FSR_CE] | err_ce_i;
      fsr_q[FSR_UE] <= fsr_q[FSR_UE] | err_ue_i;
      fsr_q[7:4]    <= err_dw_i;
      fsr_q[15:8]   <= err_syn_i;
      fsr_q[FSR_ME] <= fsr_q[FSR_ME] | fsr_q[FSR_CE] | fsr_q[FSR_UE];
      fa0_q         <= err_addr0_i;
      fa1_q         <= err_addr1_i;
      if (err_ue_i || (err_ce_i && ce_irq_en_i)) irq_q <= 1'b1;
    end else if (fsr_wr_i) begin
      fsr_q <= wdata_i;
      irq_q <= 1'b0;
    end
  end

  assign fsr_o = fsr_q;
  assign fa0_o = fa0_q;
  assign fa1_o = fa1_q;
  assign irq_o = irq_q;

  assert_irq_src_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> $past(err_valid_i));

  assert_irq_clr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fsr_wr_i && !err_valid_i) |=> !irq_q);

  assert_far_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_valid_i |=> ($stable(fa0_q) && $stable(fa1_q)));

  assert_multi_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_valid_i && (fsr_q[FSR_CE] || fsr_q[FSR_UE])) |=> fsr_q[FSR_ME]);

endmodule

// File: rtl/ecc_diag_window.sv
module ecc_diag_window #(
  parameter int unsigned VARIANT = 0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       we_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o
);

  if (VARIANT == 0) begin : g_diag
    logic [7:0] mem_q [4];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < 4; i++) mem_q[i] <= 8'h0;
      end else if (req_i && we_i) begin
        mem_q[addr_i] <= wdata_i;
      end
    end

    assign rdata_o = (req_i && !we_i) ? mem_q[addr_i] : 8'h0;
  end else begin : g_nodiag
    logic unused_diag;
    assign unused_diag = ^{clk_i, rst_ni, req_i, we_i, addr_i, wdata_i};
    assign rdata_o = 8'h0;
  end

endmodule

// File: rtl/ecc_regbank.sv
module ecc_regbank
  import ecc_regbank_pkg::*;
#(
  parameter int unsigned VARIANT = 0,
  parameter int unsigned ADDR_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cold_rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        be_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              diag_req_i,
  input  logic              diag_we_i,
  input  logic [1:0]        diag_addr_i,
  input  logic [7:0]        diag_wdata_i,
  output logic [7:0]        diag_rdata_o,
  input  logic              err_valid_i,
  input  logic              err_ce_i,
  input  logic              err_ue_i,
  input  logic [7:0]        err_syn_i,
  input  logic [3:0]        err_dw_i,
  input  logic [31:0]       err_addr0_i,
  input  logic [31:0]       err_addr1_i,
  output logic              irq_o
);

  localparam int unsigned IDX_W = ADDR_W - 2;

  logic             rst_any_n;
  logic             acc_ok, wr_en, rd_en;
  logic [IDX_W-1:0] idx;
  logic [DW-1:0]    ena, fsr, fa0, fa1;
  logic [DW-1:0]    dly_q, vid_q, dgn_q, ev0_q, ev1_q;
  logic [DW-1:0]    rd_sel;
  logic             unused_lo;

  assign rst_any_n = rst_ni & cold_rst_ni;
  assign unused_lo = ^addr_i[1:0];
  assign idx       = addr_i[ADDR_W-1:2];
  assign acc_ok    = req_i && (be_i == 4'hF);
  assign wr_en     = acc_ok && we_i;
  assign rd_en     = acc_ok && !we_i;

  ecc_enable_reg #(.VARIANT(VARIANT)) u_ena (
    .clk_i       (clk_i),
    .cold_rst_ni (cold_rst_ni),
    .rst_any_ni  (rst_any_n),
    .wr_i        (wr_en && (idx == IDX_W'(IDX_ENA))),
    .wdata_i     (wdata_i[11:0]),
    .ena_o       (ena)
  );

  ecc_fault_capture u_fault (
    .clk_i       (clk_i),
    .rst_ni      (rst_any_n),
    .fsr_wr_i    (wr_en && (idx == IDX_W'(IDX_FSR))),
    .wdata_i     (wdata_i),
    .ce_irq_en_i (ena[1]),
    .err_valid_i (err_valid_i),
    .err_ce_i    (err_ce_i),
    .err_ue_i    (err_ue_i),
    .err_syn_i   (err_syn_i),
    .err_dw_i    (err_dw_i),
    .err_addr0_i (err_addr0_i),
    .err_addr1_i (err_addr1_i),
    .fsr_o       (fsr),
    .fa0_o       (fa0),
    .fa1_o       (fa1),
    .irq_o       (irq_o)
  );

  ecc_diag_window #(.VARIANT(VARIANT)) u_diag (
    .clk_i   (clk_i),
    .rst_ni  (rst_any_n),
    .req_i   (diag_req_i),
    .we_i    (diag_we_i),
    .addr_i  (diag_addr_i),
    .wdata_i (diag_wdata_i),
    .rdata_o (diag_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_any_n) begin
    if (!rst_any_n) begin
      dly_q <= DLY_RST;
      vid_q <= '0;
      dgn_q <= '0;
      ev0_q <= '0;
      ev1_q <= '0;
    end else if (wr_en) begin
      if (idx == IDX_W'(IDX_DLY)) dly_q <= wdata_i & DLY_WMASK;
      if (idx == IDX_W'(IDX_VID)) vid_q <= wdata_i;
      if (idx == IDX_W'(IDX_DGN)) dgn_q <= wdata_i;
      if (idx == IDX_W'(IDX_EV0)) ev0_q <= wdata_i;
      if (idx == IDX_W'(IDX_EV1)) ev1_q <= wdata_i;
    end
  end

  always_comb begin
    rd_sel = '0;
    case (idx)
      IDX_W'(IDX_ENA): rd_sel = ena;
      IDX_W'(IDX_DLY): rd_sel = dly_q;
      IDX_W'(IDX_FSR): rd_sel = fsr;
      IDX_W'(IDX_VID): rd_sel = vid_q;
      IDX_W'(IDX_FA0): rd_sel = fa0;
      IDX_W'(IDX_FA1): rd_sel = fa1;
      IDX_W'(IDX_DGN): rd_sel = dgn_q;
      IDX_W'(IDX_EV0): rd_sel = ev0_q;
      IDX_W'(IDX_EV1): rd_sel = ev1_q;
      default:         rd_sel = '0;
    endcase
  end

  assign rdata_o = rd_en ? rd_sel : '0;

  assert_partial_R7: assert property (@(posedge clk_i) disable iff (!rst_any_n)
    (req_i && we_i && (be_i != 4'hF)) |=>
      ($stable(dly_q) && $stable(vid_q) && $stable(dgn_q) && $stable(ev0_q) && $stable(ev1_q)));

  assert_dly_top_R4: assert property (@(posedge clk_i) disable iff (!rst_any_n)
    (wr_en && (idx == IDX_W'(IDX_DLY))) |=> !dly_q[31]);

  assert_rd_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_any_n)
    !rd_en |-> (rdata_o == '0));

endmodule

// File: tb/ecc_regbank_bench.sv
module ecc_regbank_bench;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n, cold_n;
  logic        req, we;
  logic [5:0]  addr;
  logic [3:0]  be;
  logic [31:0] wdata;
  logic        dreq, dwe;
  logic [1:0]  daddr;
  logic [7:0]  dwdata;
  logic        ev, ce, ue;
  logic [7:0]  syn;
  logic [3:0]  dw;
  logic [31:0] a0, a1;

  logic [31:0] rd  [3];
  logic [7:0]  drd [3];
  logic        irq [3];
  logic [31:0] rv  [3];
  logic [7:0]  dv  [3];

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  ecc_regbank #(.VARIANT(0)) u_ecc_regbank (
    .clk_i(clk), .rst_ni(rst_n), .cold_rst_ni(cold_n), .req_i(req), .we_i(we),
    .addr_i(addr), .be_i(be), .wdata_i(wdata), .rdata_o(rd[0]),
    .diag_req_i(dreq), .diag_we_i(dwe), .diag_addr_i(daddr), .diag_wdata_i(dwdata),
    .diag_rdata_o(drd[0]), .err_valid_i(ev), .err_ce_i(ce), .err_ue_i(ue),
    .err_syn_i(syn), .err_dw_i(dw), .err_addr0_i(a0), .err_addr1_i(a1), .irq_o(irq[0]));

  ecc_regbank #(.VARIANT(1)) u_ecc_regbank_v1 (
    .clk_i(clk), .rst_ni(rst_n), .cold_rst_ni(cold_n), .req_i(req), .we_i(we),
    .addr_i(addr), .be_i(be), .wdata_i(wdata), .rdata_o(rd[1]),
    .diag_req_i(dreq), .diag_we_i(dwe), .diag_addr_i(daddr), .diag_wdata_i(dwdata),
    .diag_rdata_o(drd[1]), .err_valid_i(ev), .err_ce_i(ce), .err_ue_i(ue),
    .err_syn_i(syn), .err_dw_i(dw), .err_addr0_i(a0), .err_addr1_i(a1), .irq_o(irq[1]));

  ecc_regbank #(.VARIANT(2)) u_ecc_regbank_v2 (
    .clk_i(clk), .rst_ni(rst_n), .cold_rst_ni(cold_n), .req_i(req), .we_i(we),
    .addr_i(addr), .be_i(be), .wdata_i(wdata), .rdata_o(rd[2]),
    .diag_req_i(dreq), .diag_we_i(dwe), .diag_addr_i(daddr), .diag_wdata_i(dwdata),
    .diag_rdata_o(drd[2]), .err_valid_i(ev), .err_ce_i(ce), .err_ue_i(ue),
    .err_syn_i(syn), .err_dw_i(dw), .err_addr0_i(a0), .err_addr1_i(a1), .irq_o(irq[2]));

  function automatic logic [31:0] impl_of(int v);
    return 32'(v) << 28;
  endfunction

  function automatic logic [31:0] mask_of(int v);
    return (v == 0) ? 32'h103 : 32'hBFF;
  endfunction

  function automatic logic [31:0] keep_of(int v);
    return (v == 0) ? 32'h100 : 32'hBFC;
  endfunction

  task automatic chk(string tag, int v, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s variant%0d act=%h exp=%h", tag, v, act, exp);
    end
  endtask

  task automatic wr(int idx, logic [31:0] d, logic [3:0] b = 4'hF);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = {idx[3:0], 2'b00}; be = b; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0; be = 4'h0;
  endtask

  task automatic rd_w(int idx, logic [3:0] b = 4'hF);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = {idx[3:0], 2'b00}; be = b;
    #1;
    for (int v = 0; v < 3; v++) rv[v] = rd[v];
    req = 1'b0; be = 4'h0;
  endtask

  task automatic drive_rep(logic c, logic u, logic [7:0] s, logic [3:0] d,
                           logic [31:0] x0, logic [31:0] x1);
    ev = 1'b1; ce = c; ue = u; syn = s; dw = d; a0 = x0; a1 = x1;
  endtask

  task automatic rep(logic c, logic u, logic [7:0] s, logic [3:0] d,
                     logic [31:0] x0, logic [31:0] x1);
    @(negedge clk);
    drive_rep(c, u, s, d, x0, x1);
    @(negedge clk);
    ev = 1'b0;
  endtask

  task automatic chk_irq(string tag, logic exp);
    for (int v = 0; v < 3; v++) chk(tag, v, 32'(irq[v]), 32'(exp));
  endtask

  task automatic chk_all(string tag, int idx, logic [31:0] exp);
    rd_w(idx);
    for (int v = 0; v < 3; v++) chk(tag, v, rv[v], exp);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cold_n = 1'b0;
    req = 1'b0; we = 1'b0; addr = '0; be = '0; wdata = '0;
    dreq = 1'b0; dwe = 1'b0; daddr = '0; dwdata = '0;
    ev = 1'b0; ce = 1'b0; ue = 1'b0; syn = '0; dw = '0; a0 = '0; a1 = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; cold_n = 1'b1;

    // R1: cold reset values
    rd_w(0);
    for (int v = 0; v < 3; v++) chk("R1 enable", v, rv[v], impl_of(v));
    chk_all("R1 delay", 1, 32'h20);
    chk_all("R1 fault addr0", 4, 32'h07C0_0000);
    for (int i = 2; i < 16; i++) if (i != 4) chk_all("R1 zero", i, 32'h0);
    chk_irq("R1 irq", 1'b0);

    // R2: walking one and all ones through enable
    for (int b = 0; b < 33; b++) begin
      logic [31:0] d;
      d = (b == 32) ? 32'hFFFF_FFFF : (32'h1 << b);
      wr(0, d);
      rd_w(0);
      for (int v = 0; v < 3; v++) chk("R2 enable mask", v, rv[v], impl_of(v) | (d & mask_of(v)));
    end

    // R4: delay mask
    for (int b = 0; b < 33; b++) begin
      logic [31:0] d;
      d = (b == 32) ? 32'hFFFF_FFFF : (32'h1 << b);
      wr(1, d);
      chk_all("R4 delay mask", 1, d & 32'h7FFF_FFFF);
    end

    // R3: warm reset keeps selected enable fields
    wr(0, 32'hFFFF_FFFF);
    wr(1, 32'h1234);
    wr(3, 32'hA5A5_A5A5);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    rd_w(0);
    for (int v = 0; v < 3; v++)
      chk("R3 enable keep", v, rv[v], impl_of(v) | (32'hFFF & mask_of(v) & keep_of(v)));
    chk_all("R3 delay reset", 1, 32'h20);
    chk_all("R3 video reset", 3, 32'h0);

    // R11: plain storage, independent counters, unmapped indexes
    wr(3, 32'hCAFE_0001);
    wr(6, 32'h8000_0006);
    wr(7, 32'h1111_1111);
    wr(8, 32'h2222_2222);
    chk_all("R11 video", 3, 32'hCAFE_0001);
    chk_all("R11 diag reg", 6, 32'h8000_0006);
    chk_all("R11 event0", 7, 32'h1111_1111);
    chk_all("R11 event1", 8, 32'h2222_2222);
    for (int i = 9; i < 16; i++) begin
      wr(i, 32'hFFFF_FFFF);
      chk_all("R11 unmapped", i, 32'h0);
    end
    chk_all("R11 event1 after unmapped", 8, 32'h2222_2222);

    // R7: partial byte enables
    wr(1, 32'h0000_0055);
    wr(1, 32'h0000_1234, 4'h3);
    wr(3, 32'h0, 4'hE);
    chk_all("R7 partial write delay", 1, 32'h55);
    chk_all("R7 partial write video", 3, 32'hCAFE_0001);
    rd_w(1, 4'h1);
    for (int v = 0; v < 3; v++) chk("R7 partial read", v, rv[v], 32'h0);

    // R9/R10: correctable report with interrupt enable clear (bit1 cleared by warm reset)
    rep(1'b1, 1'b0, 8'h5A, 4'h3, 32'h1234_5678, 32'h9ABC_DEF0);
    chk_irq("R10 ce masked", 1'b0);
    chk_all("R9 status ce", 2, 32'h0000_5A31);
    chk_all("R9 addr0", 4, 32'h1234_5678);
    chk_all("R9 addr1", 5, 32'h9ABC_DEF0);

    // R9/R10: uncorrectable on top of ce
    rep(1'b0, 1'b1, 8'hC3, 4'hE, 32'h0BAD_F00D, 32'h0000_1111);
    chk_irq("R10 ue raises", 1'b1);
    chk_all("R9 status multi", 2, 32'h0001_C3E9);

    // R6: fault address writes ignored
    wr(4, 32'hFFFF_FFFF);
    wr(5, 32'hFFFF_FFFF);
    chk_all("R6 addr0 ro", 4, 32'h0BAD_F00D);
    chk_all("R6 addr1 ro", 5, 32'h0000_1111);

    // R5: status write stores and clears irq
    wr(2, 32'h00AA_0000);
    chk_irq("R5 irq cleared", 1'b0);
    chk_all("R5 status stored", 2, 32'h00AA_0000);

    // R10: correctable with enable bit 1 set
    wr(2, 32'h0);
    wr(0, 32'h2);
    rep(1'b1, 1'b0, 8'h11, 4'h1, 32'h0, 32'h0);
    chk_irq("R10 ce enabled", 1'b1);
    chk_all("R9 status single", 2, 32'h0000_1111);

    // R12: report beats same-cycle status write
    wr(2, 32'h0);
    chk_irq("R5 irq cleared again", 1'b0);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 6'd8; be = 4'hF; wdata = 32'hFFFF_FFFF;
    drive_rep(1'b0, 1'b1, 8'h22, 4'h2, 32'h0, 32'h0);
    @(negedge clk);
    req = 1'b0; we = 1'b0; be = 4'h0; ev = 1'b0;
    chk_irq("R12 irq kept", 1'b1);
    chk_all("R12 status from report", 2, 32'h0000_2228);

    // R8: diagnostic window
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      dreq = 1'b1; dwe = 1'b1; daddr = 2'(i); dwdata = 8'(8'h3C + 8'(i * 17));
      @(negedge clk);
      dreq = 1'b0; dwe = 1'b0;
    end
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      dreq = 1'b1; dwe = 1'b0; daddr = 2'(i);
      #1;
      for (int v = 0; v < 3; v++) dv[v] = drd[v];
      dreq = 1'b0;
      for (int v = 0; v < 3; v++)
        chk("R8 diag byte", v, 32'(dv[v]), (v == 0) ? 32'(8'h3C + 8'(i * 17)) : 32'h0);
    end

    // R1: cold reset clears preserved enable fields
    wr(0, 32'hFFFF_FFFF);
    @(negedge clk); cold_n = 1'b0;
    repeat (2) @(negedge clk); cold_n = 1'b1;
    rd_w(0);
    for (int v = 0; v < 3; v++) chk("R1 cold enable", v, rv[v], impl_of(v));
    chk_irq("R1 cold irq", 1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule